// File: doc/BRIEF.md
# Limit Status and Alert Filter

This block judges every new conversion from three measurement channels (sense voltage, source voltage and internal temperature) against a programmable upper and lower limit per channel. A result at or above its upper limit is a high fault. A result at or below its lower limit is a low fault. Faults are collected in two status bytes, one for high faults and one for low faults. In latched mode these bytes are sticky. A read of a status byte clears only the bits whose fault was absent from the most recent conversion. In comparator mode the bytes simply follow the latest conversion.

An active-low alert pin tells the host about faults. A run filter counts conversions in a row that carry at least one fault. The alert asserts only when that run has reached a programmed length, at least one status bit is set and the alert is not masked. The block is driven by a conversion-done strobe carrying all three results, and by a simple single-cycle register read/write port. Read data is combinational on the current address.

Register map (8-bit data):
- 0x01 config: bit 0 mask, bit 1 comparator mode, bits 4:2 run code.
- 0x02 summary.
- 0x20+ch upper limits.
- 0x28+ch lower limits.
- 0x35 high status.
- 0x36 low status.

Channel numbering in `res_i` is ch0 = temperature in bits 7:0, ch1 = source in bits 15:8, and ch2 = sense in bits 23:16.

Top module: `lim_alert`

## Requirements
- R1: The run code in config bits 4:2 sets the required run length: 000 gives 1, 001 gives 2, 011 gives 3 and 111 gives 4 conversions in a row.
- R2: The run codes 010, 100, 101 and 110 give a run length of 1.
- R3: A channel's high flag is raised when its result is greater than or equal to its upper limit. Its low flag is raised when its result is less than or equal to its lower limit.
- R4: The high status at 0x35 and the low status at 0x36 both use this layout: bit 7 is sense (ch2), bit 6 is source (ch1) and bit 0 is temperature (ch0). Bits 5:1 read 0.
- R5: Summary register 0x02 bit 1 is the OR of all high status bits, and bit 0 is the OR of all low status bits. Bits 7:2 read 0.
- R6: In latched mode a status bit stays set until a read of its register. That read returns the bit and then clears it only if the latest conversion did not show that fault.
- R7: If a status read and a conversion that raises a flag occur in the same cycle, the flag is set afterwards.
- R8: A conversion with no fault resets the run count to zero. A faulty conversion increments the count, which saturates at the required length.
- R9: `alert_no` is low exactly when the config mask bit 0 is 0, the run count has reached the required length, and any high or low status bit is set.
- R10: In comparator mode (config bit 1 = 1) every status bit equals the fault found by the latest conversion, and reads do not change it.
- R11: After reset, config is 00h, upper limits are FFh, lower limits are 00h, both status bytes are 00h and `alert_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | One-cycle strobe: new conversion results are valid |
| res_i | input | 24 | Results, ch0 in bits 7:0, ch1 in bits 15:8, ch2 in bits 23:16 |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (triggers read-to-clear) |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| alert_no | output | 1 | Alert, active low |

## Verification
The assertions take `conv_i` and `re_i` to be single-cycle strobes that are sampled together with the address. They also assume that configuration does not change in the same cycle as a conversion that the properties reason about. The stimulus drives every strobe for exactly one cycle between falling edges. It changes the config register only between conversions. It also runs a conversion free of faults before each run-length sweep, so every sweep starts from a run count of zero.

// File: rtl/lim_alert_pkg.sv
package lim_alert_pkg;
  localparam int unsigned NCH = 3;

  localparam logic [7:0] ADDR_CFG   = 8'h01;
  localparam logic [7:0] ADDR_SUM   = 8'h02;
  localparam logic [7:0] ADDR_HLIM  = 8'h20;
  localparam logic [7:0] ADDR_LLIM  = 8'h28;
  localparam logic [7:0] ADDR_HSTAT = 8'h35;
  localparam logic [7:0] ADDR_LSTAT = 8'h36;

  typedef struct packed {
    logic [2:0] run_code;
    logic       cmp_mode;
    logic       mask;
  } cfg_t;

  // thermometer code to run length; anything else means a single conversion
  function automatic logic [2:0] run_need(input logic [2:0] code);
    case (code)
      3'b001:  run_need = 3'd2;
      3'b011:  run_need = 3'd3;
      3'b111:  run_need = 3'd4;
      default: run_need = 3'd1;
    endcase
  endfunction

  // bit position of a channel flag inside a status byte
  function automatic int unsigned flag_bit(input int unsigned ch);
    case (ch)
      0:       flag_bit = 0;
      1:       flag_bit = 6;
      default: flag_bit = 7;
    endcase
  endfunction
endpackage

// File: rtl/lim_cmp.sv
module lim_cmp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] hi_lim_i,
  input  logic [DW-1:0] lo_lim_i,
  output logic          hi_o,
  output logic          lo_o
);
  assign hi_o = (val_i >= hi_lim_i);
  assign lo_o = (val_i <= lo_lim_i);
endmodule

// File: rtl/lim_status.sv
module lim_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         conv_i,
  input  logic [N-1:0] fault_i,
  input  logic         cmp_mode_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] live_q, stat_q, stat_d;

  always_comb begin
    if (cmp_mode_i) begin
      stat_d = conv_i ? fault_i : live_q;
    end else begin
      stat_d = clr_i ? (stat_q & live_q) : stat_q;
      if (conv_i) stat_d = stat_d | fault_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      stat_q <= '0;
    end else begin
      if (conv_i) live_q <= fault_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R7: a flag raised by a conversion is present on the next cycle in latched mode
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !cmp_mode_i) |=> ((stat_q & $past(fault_i)) == $past(fault_i)));

  // R6: a clearing read with no conversion keeps only live faults
  a_r6_clear_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !conv_i && !cmp_mode_i) |=> (stat_q == $past(stat_q & live_q)));

  // R10: comparator mode mirrors the conversion
  a_r10_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && cmp_mode_i) |=> (stat_q == $past(fault_i)));
endmodule

// File: rtl/lim_run_filter.sv
module lim_run_filter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_i,
  input  logic       any_i,
  input  logic [2:0] need_i,
  output logic       hit_o
);
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (conv_i) begin
      if (!any_i)                cnt_q <= '0;
      else if (cnt_q >= need_i)  cnt_q <= need_i;
      else                       cnt_q <= cnt_q + 3'd1;
    end
  end

  assign hit_o = (cnt_q >= need_i);

  // R8: a conversion without faults resets the run
  a_r8_clean_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !any_i) |=> (cnt_q == 3'd0));

  // R8: count never runs past the longest run length
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 3'd4);
endmodule

// File: rtl/lim_alert.sv
module lim_alert
  import lim_alert_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            conv_i,
  input  logic [NCH*DW-1:0] res_i,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [7:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            alert_no
);
  localparam int unsigned CFGW = $bits(cfg_t);

  cfg_t              cfg_q;
  logic [NCH-1:0][DW-1:0] hi_lim_q, lo_lim_q;
  logic [NCH-1:0]    hi_now, lo_now, hi_stat, lo_stat;
  logic              any_fault, run_hit, alert_act;
  logic [DW-1:0]     hi_byte, lo_byte;

  // configuration and limit registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && addr_i == ADDR_CFG) begin
      cfg_q <= cfg_t'(wdata_i[CFGW-1:0]);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_lim_q[c] <= '1;
        lo_lim_q[c] <= '0;
      end else if (we_i) begin
        if (addr_i == ADDR_HLIM + 8'(c)) hi_lim_q[c] <= wdata_i;
        if (addr_i == ADDR_LLIM + 8'(c)) lo_lim_q[c] <= wdata_i;
      end
    end

    lim_cmp #(.DW(DW)) u_cmp (
      .val_i    (res_i[c*DW +: DW]),
      .hi_lim_i (hi_lim_q[c]),
      .lo_lim_i (lo_lim_q[c]),
      .hi_o     (hi_now[c]),
      .lo_o     (lo_now[c])
    );
  end

  assign any_fault = (|hi_now) | (|lo_now);

  lim_status #(.N(NCH)) u_hi_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_i     (conv_i),
    .fault_i    (hi_now),
    .cmp_mode_i (cfg_q.cmp_mode),
    .clr_i      (re_i && addr_i == ADDR_HSTAT),
    .stat_o     (hi_stat)
  );

  lim_status #(.N(NCH)) u_lo_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_i     (conv_i),
    .fault_i    (lo_now),
    .cmp_mode_i (cfg_q.cmp_mode),
    .clr_i      (re_i && addr_i == ADDR_LSTAT),
    .stat_o     (lo_stat)
  );

  lim_run_filter u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .conv_i (conv_i),
    .any_i  (any_fault),
    .need_i (run_need(cfg_q.run_code)),
    .hit_o  (run_hit)
  );

  always_comb begin
    hi_byte = '0;
    lo_byte = '0;
    for (int unsigned c = 0; c < NCH; c++) begin
      hi_byte[flag_bit(c)] = hi_stat[c];
      lo_byte[flag_bit(c)] = lo_stat[c];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CFG:   rdata_o[CFGW-1:0] = cfg_q;
      ADDR_SUM:   rdata_o[1:0] = {|hi_stat, |lo_stat};
      ADDR_HSTAT: rdata_o = hi_byte;
      ADDR_LSTAT: rdata_o = lo_byte;
      default: begin
        for (int unsigned c = 0; c < NCH; c++) begin
          if (addr_i == ADDR_HLIM + 8'(c)) rdata_o = hi_lim_q[c];
          if (addr_i == ADDR_LLIM + 8'(c)) rdata_o = lo_lim_q[c];
        end
      end
    endcase
  end

  assign alert_act = !cfg_q.mask && run_hit && ((|hi_stat) || (|lo_stat));
  assign alert_no  = !alert_act;

  // R9: an asserted alert is never masked and always has a status bit behind it
  a_r9_alert_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alert_no |-> (!cfg_q.mask && ((|hi_stat) || (|lo_stat))));

  // R8: a conversion free of faults drops the alert on the next cycle
  a_r8_clean_drops_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !any_fault) |=> alert_no);
endmodule

// File: tb/tb_lim_alert.sv
module tb_lim_alert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv = 1'b0, we = 1'b0, re = 1'b0;
  logic [23:0] res = '0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        alert_n;
  int          n_chk = 0, n_err = 0;
  logic [7:0]  v;

  always #2 clk = ~clk;

  lim_alert dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .res_i(res),
    .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .alert_no(alert_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic cv(input logic [7:0] t, input logic [7:0] s, input logic [7:0] e);
    @(negedge clk); conv = 1'b1; res = {e, s, t};
    @(negedge clk); conv = 1'b0;
  endtask

  function automatic int need_of(input int code);
    case (code)
      1: return 2;
      3: return 3;
      7: return 4;
      default: return 1;
    endcase
  endfunction

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 alert", {7'd0, alert_n}, 8'h01);
    rd(8'h01, v); chk("R11 cfg", v, 8'h00);
    rd(8'h20, v); chk("R11 hlim", v, 8'hFF);
    rd(8'h28, v); chk("R11 llim", v, 8'h00);
    rd(8'h35, v); chk("R4 hstat reset", v, 8'h00);
    rd(8'h36, v); chk("R4 lstat reset", v, 8'h00);

    for (int c = 0; c < 3; c++) begin
      wr(8'h20 + 8'(c), 8'h80);
      wr(8'h28 + 8'(c), 8'h20);
    end

    // R3 upper boundary sweep on ch0, ascending keeps sticky bits consistent
    for (int x = 8'h7C; x <= 8'h84; x++) begin
      cv(8'(x), 8'h50, 8'h50);
      rd(8'h35, v); chk("R3 high cmp", v, (x >= 8'h80) ? 8'h01 : 8'h00);
    end
    cv(8'h50, 8'h50, 8'h50); rd(8'h35, v); rd(8'h35, v);
    chk("R6 cleared after clean conv", v, 8'h00);
    // R3 lower boundary sweep, descending
    for (int x = 8'h24; x >= 8'h1C; x--) begin
      cv(8'(x), 8'h50, 8'h50);
      rd(8'h36, v); chk("R3 low cmp", v, (x <= 8'h20) ? 8'h01 : 8'h00);
    end
    cv(8'h50, 8'h50, 8'h50); rd(8'h36, v); rd(8'h36, v);

    // R4 bit positions for source and sense
    cv(8'h50, 8'h90, 8'h50); rd(8'h35, v); chk("R4 source high bit6", v, 8'h40);
    cv(8'h50, 8'h50, 8'h90); rd(8'h35, v); chk("R4 sense high bit7", v, 8'hC0);
    cv(8'h50, 8'h10, 8'h10); rd(8'h36, v); chk("R4 low bits 7 and 6", v, 8'hC0);
    // R5 summary while both bytes hold faults
    rd(8'h02, v); chk("R5 summary both", v, 8'h03);
    cv(8'h50, 8'h50, 8'h50);
    rd(8'h35, v); rd(8'h36, v);
    rd(8'h02, v); chk("R5 summary cleared", v, 8'h00);
    cv(8'h90, 8'h50, 8'h50); rd(8'h02, v); chk("R5 summary high only", v, 8'h02);

    // R6 read keeps a fault that is still live
    rd(8'h35, v); chk("R6 live read", v, 8'h01);
    rd(8'h35, v); chk("R6 live kept", v, 8'h01);
    cv(8'h50, 8'h50, 8'h50);
    rd(8'h35, v); chk("R6 sticky after clean", v, 8'h01);
    rd(8'h35, v); chk("R6 cleared by read", v, 8'h00);

    // R7 read and new fault in the same cycle
    cv(8'h90, 8'h50, 8'h50);
    cv(8'h50, 8'h50, 8'h50);
    @(negedge clk); re = 1'b1; addr = 8'h35; conv = 1'b1; res = {8'h50, 8'h50, 8'h90};
    @(negedge clk); re = 1'b0; conv = 1'b0;
    rd(8'h35, v); chk("R7 set wins", v, 8'h01);

    // R1 R2 R8 run-length sweep over every code
    for (int code = 0; code < 8; code++) begin
      wr(8'h01, 8'(code << 2));
      cv(8'h50, 8'h50, 8'h50);
      rd(8'h35, v); rd(8'h36, v);
      for (int j = 1; j <= 5; j++) begin
        cv(8'h50, 8'h50, 8'h90);
        chk((code == 0 || code == 1 || code == 3 || code == 7) ? "R1 run length" : "R2 reserved code",
            {7'd0, alert_n}, (j >= need_of(code)) ? 8'h00 : 8'h01);
      end
      cv(8'h50, 8'h50, 8'h50);
      chk("R8 clean conv resets run", {7'd0, alert_n}, 8'h01);
    end

    // R9 mask blocks, unmask releases
    wr(8'h01, 8'h01);
    cv(8'h90, 8'h50, 8'h50);
    chk("R9 masked", {7'd0, alert_n}, 8'h01);
    wr(8'h01, 8'h00);
    chk("R9 unmasked", {7'd0, alert_n}, 8'h00);

    // R10 comparator mode follows conversions
    wr(8'h01, 8'h02);
    cv(8'h50, 8'h50, 8'h50);
    chk("R10 drop without read", {7'd0, alert_n}, 8'h01);
    rd(8'h35, v); chk("R10 follows clean", v, 8'h00);
    cv(8'h90, 8'h50, 8'h10);
    rd(8'h35, v); chk("R10 follows high", v, 8'h01);
    rd(8'h35, v); chk("R10 read keeps", v, 8'h01);
    rd(8'h36, v); chk("R10 follows low", v, 8'h80);
    chk("R10 alert", {7'd0, alert_n}, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule